// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block sits on the host side of a parallel ATA cable. It turns single register reads and writes on a small internal bus into programmed I/O cycles. A host access carries a byte offset, a direction and write data. The engine decodes the offset into the two active-low chip selects and the three device address lines. It then runs one bus cycle in three phases: setup, strobe and recovery. The length of each phase comes from configuration inputs counted in clock cycles, so a single engine covers the slow and fast PIO modes. When the cycle ends, the engine raises a one-cycle done flag.

During the strobe, a low ready line from the drive stretches the cycle. A bounded wait closes a stuck cycle and reports an error. For reads, the engine captures the bus when the strobe is released. Only the 16-bit data register returns the full word; every other task-file register returns a byte, zero-extended. For writes, the data bus is enabled from setup to the end of recovery, and narrow registers have their upper byte forced to zero. A separate direction output steers the external transceiver. It is high for transfers toward the drive and low otherwise.

Task-file registers sit four bytes apart. The read-only and write-only registers that share an address (status/command, error/features, alternate status/device control) are told apart only by which strobe is pulsed. Device 0/1 selection and LBA mode are bits that the host writes into the device/head register (bit 4 and bit 6). The engine passes them through as plain data.

Top module: `ata_pio_engine`

## Requirements
- R1: Offsets CMD_BASE + 4*i for i = 0..7 (default CMD_BASE = 0x3A60) drive chip select 0 low, chip select 1 high and the device address lines to i, for the whole cycle.
- R2: Offset CTRL_OFS (default 0x3A5C) drives chip select 0 high, chip select 1 low and the device address lines to 110.
- R3: Any other offset, including a misaligned one, makes done and err high on the cycle after the request. Both chip selects and both strobes stay high.
- R4: The two chip selects are never low together.
- R5: The direction output is high for the whole of a write cycle and low for the whole of a read cycle. The data bus output enable equals the direction output whenever a chip select is active.
- R6: The address is valid with both strobes high for max(setup,1) cycles. The strobe is then low for max(active,1) cycles, and the address then stays valid with the strobes high for max(recovery,1) cycles. Done follows on the next cycle.
- R7: If the ready line is sampled low on k < TIMEOUT_CYC consecutive cycles once the base strobe width is reached, the strobe is extended by k cycles and err stays low.
- R8: If the ready line is sampled low on TIMEOUT_CYC consecutive cycles, the strobe ends after max(active,1)+TIMEOUT_CYC-1 cycles and done comes with err high.
- R9: Read data is the bus value at the edge where the read strobe is released. The data register (index 0) returns all 16 bits, and the other registers return bits 7:0 with bits 15:8 zero.
- R10: Write data is driven from the first setup cycle through the last recovery cycle. For registers other than the data register, bits 15:8 on the bus are zero.
- R11: A request that arrives while a cycle is running is ignored, and done is a single-cycle pulse per accepted or rejected request.
- R12: At most one strobe is low at a time, and a strobe is low only while a chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (16) | Register byte offset |
| wdata_i | input | DW (16) | Write data |
| rdata_o | output | DW (16) | Read data, valid with done |
| done_o | output | 1 | Access finished, one-cycle pulse |
| err_o | output | 1 | Unmapped offset or ready timeout, valid with done |
| t_setup_i | input | CW (8) | Setup cycles (0 treated as 1) |
| t_active_i | input | CW (8) | Base strobe cycles (0 treated as 1) |
| t_recov_i | input | CW (8) | Recovery cycles (0 treated as 1) |
| cs0_no | output | 1 | Command block chip select, active low |
| cs1_no | output | 1 | Control block chip select, active low |
| da_o | output | 3 | Device address lines |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dd_o | output | DW (16) | Data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| dd_i | input | DW (16) | Data bus in |
| iordy_i | input | 1 | Drive ready, low stretches the strobe |
| dir_o | output | 1 | Transceiver direction, 1 = toward drive |

## Verification
A wrong phase counter shows within one access as a setup, strobe or recovery width at the pins that differs from the configured value. A wrong ready-wait count shows as a strobe that is longer or shorter than the stall the drive applied, or as a stuck cycle that ends without err. A bad decode or a stale latched address shows on the first cycle that a chip select goes low, because the bench compares the chip select and address lines on every clock with its own map. A read capture on the wrong edge, or a missed upper-byte mask, shows in rdata_o on the done cycle, because the modelled drive puts a distinct pattern on the bus outside the read strobe and in the upper byte of narrow registers.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

  typedef struct packed {
    logic       cs0_n;
    logic       cs1_n;
    logic [2:0] da;
  } bus_addr_t;
endpackage

// File: rtl/ata_pio_decode.sv
module ata_pio_decode
  import ata_pio_pkg::*;
#(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   CMD_BASE = 16'h3A60,
  parameter logic [AW-1:0]   CTRL_OFS = 16'h3A5C
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          wide_o,
  output bus_addr_t     ba_o
);
  localparam int DAW    = 3;
  localparam int NREG   = 1 << DAW;
  localparam int STRIDE = 4;

  always_comb begin
    hit_o  = 1'b0;
    wide_o = 1'b0;
    ba_o   = '{cs0_n: 1'b1, cs1_n: 1'b1, da: '0};
    if (addr_i == CTRL_OFS) begin
      hit_o = 1'b1;
      ba_o  = '{cs0_n: 1'b1, cs1_n: 1'b0, da: 3'b110};
    end
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == AW'(int'(CMD_BASE) + i * STRIDE)) begin
        hit_o  = 1'b1;
        wide_o = (i == 0);
        ba_o   = '{cs0_n: 1'b0, cs1_n: 1'b1, da: DAW'(i)};
      end
    end
  end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CW          = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] t_setup_i,
  input  logic [CW-1:0] t_active_i,
  input  logic [CW-1:0] t_recov_i,
  input  logic          iordy_i,
  output phase_e        phase_o,
  output logic          take_o,
  output logic          fin_o,
  output logic          tout_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] wcnt_q;
  logic          fin_q, tout_q;
  logic [CW-1:0] ts_eff, ta_eff, tr_eff;
  logic          base_done, wait_expired;

  assign ts_eff = (t_setup_i  == '0) ? CW'(1) : t_setup_i;
  assign ta_eff = (t_active_i == '0) ? CW'(1) : t_active_i;
  assign tr_eff = (t_recov_i  == '0) ? CW'(1) : t_recov_i;

  assign base_done    = (phase_q == PH_ACTIVE) && (cnt_q >= ta_eff - CW'(1));
  assign wait_expired = (wcnt_q == TW'(TIMEOUT_CYC - 1));
  // strobe release edge: normal end or timeout
  assign take_o = base_done && (iordy_i || wait_expired);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      fin_q   <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= '0;
          tout_q  <= 1'b0;
        end
        PH_SETUP: begin
          if (cnt_q >= ts_eff - CW'(1)) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= '0;
            wcnt_q  <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        PH_ACTIVE: begin
          if (!base_done) cnt_q <= cnt_q + CW'(1);
          else if (take_o) begin
            phase_q <= PH_RECOV;
            cnt_q   <= '0;
            tout_q  <= !iordy_i;
          end else wcnt_q <= wcnt_q + TW'(1);
        end
        PH_RECOV: begin
          if (cnt_q >= tr_eff - CW'(1)) begin
            phase_q <= PH_IDLE;
            fin_q   <= 1'b1;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign fin_o   = fin_q;
  assign tout_o  = tout_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q);

  // R6
  fin_from_recov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin_q) |-> $past(phase_q == PH_RECOV));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            DW          = 16,
  parameter int            CW          = 8,
  parameter int            TIMEOUT_CYC = 64,
  parameter logic [AW-1:0] CMD_BASE    = 16'h3A60,
  parameter logic [AW-1:0] CTRL_OFS    = 16'h3A5C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  input  logic [CW-1:0] t_setup_i,
  input  logic [CW-1:0] t_active_i,
  input  logic [CW-1:0] t_recov_i,
  output logic          cs0_no,
  output logic          cs1_no,
  output logic [2:0]    da_o,
  output logic          dior_no,
  output logic          diow_no,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic [DW-1:0] dd_i,
  input  logic          iordy_i,
  output logic          dir_o
);
  localparam int NW = DW / 2;

  logic      hit, wide;
  bus_addr_t ba_d, ba_q;
  phase_e    phase;
  logic      take, fin, tout, busy, start;
  logic      we_q, wide_q, inv_q;
  logic [DW-1:0] wdata_q, rdata_q;

  ata_pio_decode #(.AW(AW), .CMD_BASE(CMD_BASE), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .wide_o (wide),
    .ba_o   (ba_d)
  );

  assign busy  = (phase != PH_IDLE);
  assign start = req_i && !busy && hit;

  ata_pio_seq #(.CW(CW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .t_setup_i  (t_setup_i),
    .t_active_i (t_active_i),
    .t_recov_i  (t_recov_i),
    .iordy_i    (iordy_i),
    .phase_o    (phase),
    .take_o     (take),
    .fin_o      (fin),
    .tout_o     (tout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ba_q    <= '{cs0_n: 1'b1, cs1_n: 1'b1, da: '0};
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      inv_q <= req_i && !busy && !hit;
      if (start) begin
        ba_q    <= ba_d;
        we_q    <= we_i;
        wide_q  <= wide;
        wdata_q <= wide ? wdata_i : {{(DW-NW){1'b0}}, wdata_i[NW-1:0]};
      end
      if (take && !we_q)
        rdata_q <= wide_q ? dd_i : {{(DW-NW){1'b0}}, dd_i[NW-1:0]};
    end
  end

  assign cs0_no  = busy ? ba_q.cs0_n : 1'b1;
  assign cs1_no  = busy ? ba_q.cs1_n : 1'b1;
  assign da_o    = busy ? ba_q.da : 3'b000;
  assign dior_no = !((phase == PH_ACTIVE) && !we_q);
  assign diow_no = !((phase == PH_ACTIVE) &&  we_q);
  assign dir_o   = busy && we_q;
  assign dd_oe_o = busy && we_q;
  assign dd_o    = (busy && we_q) ? wdata_q : '0;
  assign rdata_o = rdata_q;
  assign done_o  = fin || inv_q;
  assign err_o   = inv_q || (fin && tout);

  // R4
  cs_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs0_no && !cs1_no));

  // R12
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> ((dior_no || diow_no) && (!cs0_no || !cs1_no)));

  // R5
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !diow_no |-> (dir_o && dd_oe_o));

  // R5
  dir_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dior_no |-> (!dir_o && !dd_oe_o));

  // R6
  setup_before_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dior_no) || $fell(diow_no)) |-> $past(!cs0_no || !cs1_no));

  // R10
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(diow_no) |-> dd_oe_o);

  // R3
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy && !hit) |=> (done_o && err_o && cs0_no && cs1_no));
endmodule

// File: tb/tb_ata_pio_engine.sv
module tb_ata_pio_engine;
  localparam int TO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic        done, err;
  logic [7:0]  ts = 8'd2, ta = 8'd3, tr = 8'd2;
  logic        cs0_n, cs1_n, dior_n, diow_n, dd_oe, dir;
  logic [2:0]  da;
  logic [15:0] dd_out, dd_in = 16'hBAD0;
  logic        iordy = 1'b1;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] mdl [0:15];

  always #5 clk = ~clk;

  ata_pio_engine #(.TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .err_o(err),
    .t_setup_i(ts), .t_active_i(ta), .t_recov_i(tr),
    .cs0_no(cs0_n), .cs1_no(cs1_n), .da_o(da), .dior_no(dior_n), .diow_no(diow_n),
    .dd_o(dd_out), .dd_oe_o(dd_oe), .dd_i(dd_in), .iordy_i(iordy), .dir_o(dir)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // drive-side read view: status/error/alt status are read-only constants
  function automatic logic [15:0] drive_read(input int idx);
    case (idx)
      0:       return mdl[0];
      1:       return 16'hEE04;
      7:       return 16'hEE50;
      14:      return 16'hEE51;
      default: return {8'hEE, mdl[idx][7:0]};
    endcase
  endfunction

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] wd,
                        input int s_cfg, input int a_cfg, input int r_cfg, input int stall,
                        input bit hit, input int idx, input bit poke, input string tag);
    int s = 0, l = 0, r = 0;
    bit seen = 0, got = 0, e = 0, pat_ok = 1, dir_ok = 1, oe_ok = 1, stb_ok = 1;
    logic [15:0] rd = '0, cap = '0, exp_rd;
    int es = (s_cfg == 0) ? 1 : s_cfg;
    int ea = (a_cfg == 0) ? 1 : a_cfg;
    int er = (r_cfg == 0) ? 1 : r_cfg;
    int el = (stall < TO) ? ea + stall : ea + TO - 1;
    bit eerr = !hit || (stall >= TO);
    exp_rd = (idx == 0) ? mdl[0] : {8'h00, drive_read(idx) & 16'h00FF};
    @(negedge clk);
    ts = 8'(s_cfg); ta = 8'(a_cfg); tr = 8'(r_cfg);
    req = 1'b1; we = w; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 600 && !got; k++) begin
      if (k > 0) @(negedge clk);
      if (!(cs0_n && cs1_n)) begin
        if (cs0_n != (idx >= 8) || cs1_n != (idx < 8) || da != 3'(idx)) pat_ok = 0;
        if (dir != w) dir_ok = 0;
        if (dd_oe != w) oe_ok = 0;
        if ((w && !dior_n) || (!w && !diow_n)) stb_ok = 0;
        if (w ? !diow_n : !dior_n) begin
          l++; seen = 1;
          if (w) cap = dd_out; else dd_in = drive_read(idx);
          iordy = !(l >= ea && l < ea + stall);
        end else if (!seen) s++;
        else begin r++; dd_in = 16'hBAD0; iordy = 1'b1; end
      end else if (!dior_n || !diow_n) stb_ok = 0;
      if (done) begin got = 1; e = err; rd = rdata; end
      if (poke) begin
        if (k == 1) begin req = 1'b1; addr = 16'h3A5C; we = !w; end
        else req = 1'b0;
      end
    end
    iordy = 1'b1; dd_in = 16'hBAD0; req = 1'b0;
    chk(got, {tag, " R11 done seen"}, got, 1);
    chk(e == eerr, {tag, " R3/R8 err"}, e, eerr);
    chk(stb_ok, {tag, " R12 strobe"}, stb_ok, 1);
    if (hit) begin
      chk(pat_ok, {tag, " R1/R2 cs-da pattern"}, pat_ok, 1);
      chk(dir_ok && oe_ok, {tag, " R5 direction"}, {dir_ok, oe_ok}, 2'b11);
      chk(s == es, {tag, " R6 setup width"}, s, es);
      chk(l == el, {tag, " R6/R7/R8 strobe width"}, l, el);
      chk(r == er, {tag, " R6 recovery width"}, r, er);
      if (w) begin
        logic [15:0] ew = (idx == 0) ? wd : {8'h00, wd[7:0]};
        chk(cap == ew, {tag, " R10 write data"}, cap, ew);
        mdl[idx] = cap;
      end else if (stall < TO) begin
        chk(rd == exp_rd, {tag, " R9 read data"}, rd, exp_rd);
      end
    end else begin
      chk(s == 0 && l == 0 && r == 0, {tag, " R3 no bus activity"}, s + l + r, 0);
    end
    @(negedge clk);
    chk(!done, {tag, " R11 single done"}, done, 0);
    if (poke) begin
      bit quiet = 1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!cs0_n || !cs1_n || done) quiet = 0;
      end
      chk(quiet, {tag, " R11 busy request ignored"}, quiet, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(cs0_n && cs1_n && dior_n && diow_n && !dd_oe && !dir && !done,
        "reset idle bus R4 R5", {cs0_n, cs1_n, dior_n, diow_n, dd_oe, dir, done}, 7'b1111000);
    rst_n = 1'b1;
    // R1 R10 R9 R6: every command-block register, write then read
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v = (i == 0) ? 16'h1234 : 16'hFF00 | 16'(8'h31 * i);
      if (i == 6) v = 16'hAAF0;  // device/head: device 1, LBA
      access(1'b1, 16'h3A60 + 16'(4 * i), v, 2, 3, 2, 0, 1'b1, i, 1'b0, "wr_cmd");
      access(1'b0, 16'h3A60 + 16'(4 * i), 16'h0, 2, 3, 2, 0, 1'b1, i, 1'b0, "rd_cmd");
    end
    access(1'b1, 16'h3A78, 16'h00E0, 1, 1, 1, 0, 1'b1, 6, 1'b0, "devhead_dev0");
    access(1'b0, 16'h3A78, 16'h0, 1, 1, 1, 0, 1'b1, 6, 1'b0, "devhead_rd");
    // R2: control block offset
    access(1'b1, 16'h3A5C, 16'h5502, 2, 3, 2, 0, 1'b1, 14, 1'b0, "wr_ctrl");
    access(1'b0, 16'h3A5C, 16'h0, 2, 3, 2, 0, 1'b1, 14, 1'b0, "rd_ctrl");
    // R6: zero config treated as one, and long phases
    access(1'b1, 16'h3A60, 16'hBEEF, 0, 0, 0, 0, 1'b1, 0, 1'b0, "zero_cfg");
    access(1'b0, 16'h3A60, 16'h0, 5, 6, 4, 0, 1'b1, 0, 1'b0, "slow_cfg");
    // R7: ready stretch below limit, R8: stuck ready
    access(1'b0, 16'h3A68, 16'h0, 2, 3, 2, 3, 1'b1, 2, 1'b0, "stall3");
    access(1'b1, 16'h3A6C, 16'h0077, 2, 3, 2, TO - 1, 1'b1, 3, 1'b0, "stall_max");
    access(1'b0, 16'h3A70, 16'h0, 2, 3, 2, TO, 1'b1, 4, 1'b0, "timeout");
    // R3: unmapped, misaligned, past end, zero
    access(1'b0, 16'h3A58, 16'h0, 2, 3, 2, 0, 1'b0, 0, 1'b0, "below_map");
    access(1'b1, 16'h3A62, 16'h1, 2, 3, 2, 0, 1'b0, 0, 1'b0, "misaligned");
    access(1'b0, 16'h3A80, 16'h0, 2, 3, 2, 0, 1'b0, 0, 1'b0, "past_end");
    access(1'b1, 16'h0000, 16'h0, 2, 3, 2, 0, 1'b0, 0, 1'b0, "zero_ofs");
    // R11: request during a running cycle
    access(1'b1, 16'h3A64, 16'h0042, 2, 3, 2, 0, 1'b1, 1, 1'b1, "busy_poke");
    access(1'b0, 16'h3A64, 16'h0, 2, 3, 2, 0, 1'b1, 1, 1'b0, "rd_error_reg");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule